// File: doc/BRIEF.md
# Compare-and-Skip Condition Unit

This unit decides whether the instruction that follows a conditional-skip instruction is cancelled. The processor it serves has no status flags. A conditional branch is built by placing an unconditional branch directly after a skip. When the skip's condition holds, the branch is cancelled and execution falls through. Otherwise the branch runs.

Two instruction kinds can raise the cancel request. A compare-skip tests operand 1 against operand 2 under a 3-bit condition code. The code has no unsigned greater-than forms; software swaps the operands instead. An add-skip tests the already computed sum of its operands for zero or for non-zero. The unit also expands the small signed immediate that may stand in for operand 1.

The decision is registered in `skip_next`. That flag is consumed by the next accepted instruction slot. It holds its value while the pipeline stalls or no instruction is offered. A cancelled instruction never raises a new request of its own.

Top module: `skip_cond_unit`

## Requirements
- R1: After reset, `skip_next` is 0.
- R2: When `imm_sel` is 1, `op1_eff` is the sign-extended value of `imm_code`, where codes 0 to 7 give 1, 2, 4, 8, -8, -4, -2, -1. When `imm_sel` is 0, `op1_eff` equals `op1_reg`. The path is combinational.
- R3: A compare-skip (`kind` = 01) with condition 000 sets `skip_next` when `op1_eff` equals `op2`. With condition 001 it sets the flag when they differ.
- R4: A compare-skip with conditions 010, 011, 100 and 101 compares the operands as two's-complement numbers, in this order: less-than, less-or-equal, greater-than, greater-or-equal.
- R5: A compare-skip with condition 110 compares the operands unsigned for less-than, and with 111 for less-or-equal.
- R6: An add-skip on zero (`kind` = 10) sets `skip_next` exactly when `sum` is 0.
- R7: An add-skip on non-zero (`kind` = 11) sets `skip_next` exactly when `sum` is not 0.
- R8: An instruction accepted while `skip_next` is 1 is cancelled and clears `skip_next`, whatever its kind and operands. A cancelled instruction therefore never sets the flag, so the flag cancels exactly one slot.
- R9: `skip_next` changes only on a clock edge where `in_valid` is 1 and `stall` is 0. It holds otherwise.
- R10: A plain instruction (`kind` = 00), accepted while `skip_next` is 0, leaves `skip_next` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is present in this slot |
| stall | input | 1 | The slot is held; the instruction is not accepted |
| kind | input | 2 | 00 plain, 01 compare-skip, 10 add-skip on zero, 11 add-skip on non-zero |
| imm_sel | input | 1 | Operand 1 comes from the immediate code |
| imm_code | input | 3 | Encoded small immediate for operand 1 |
| op1_reg | input | 16 | Operand 1 from the register file |
| op2 | input | 16 | Operand 2 |
| cond | input | 3 | Compare condition code |
| sum | input | 16 | Add result of an add-skip |
| op1_eff | output | 16 | Operand 1 after immediate expansion |
| skip_next | output | 1 | The next accepted instruction is cancelled |

## Verification
The operand pairs are chosen to separate the signed and unsigned orderings. Pairs such as 0x8000 against 0x7FFF, and 0xFFFF against 1, flip the result between the two orderings. A design that mixed up signedness, or swapped the less/greater conditions, would set the flag on the wrong pairs. Back-to-back skips whose conditions both hold show whether a cancelled skip wrongly re-arms the flag, which would cancel two slots instead of one. Stall cycles and idle cycles placed between a skip and its victim catch a flag that is consumed or dropped early. Each negative immediate code is checked, which exposes a wrong sign extension or a misordered code table.

// File: rtl/skip_cond_unit.sv
module skip_cond_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         stall,
  input  logic [1:0]   kind,
  input  logic         imm_sel,
  input  logic [2:0]   imm_code,
  input  logic [W-1:0] op1_reg,
  input  logic [W-1:0] op2,
  input  logic [2:0]   cond,
  input  logic [W-1:0] sum,
  output logic [W-1:0] op1_eff,
  output logic         skip_next
);

  localparam logic [1:0] K_PLAIN = 2'b00;
  localparam logic [1:0] K_CMP   = 2'b01;
  localparam logic [1:0] K_ADDZ  = 2'b10;
  localparam logic [1:0] K_ADDNZ = 2'b11;

  logic [W-1:0] imm_val;
  logic         take;
  logic         eq, slt, ult;
  logic         cmp_hit;
  logic         trig;

  always_comb begin
    imm_val = '0;
    if (imm_code[2]) imm_val = -(W'(8) >> imm_code[1:0]);
    else             imm_val = W'(1) << imm_code[1:0];
  end

  assign op1_eff = imm_sel ? imm_val : op1_reg;
  assign take    = in_valid && !stall;

  assign eq  = (op1_eff == op2);
  assign slt = ($signed(op1_eff) < $signed(op2));
  assign ult = (op1_eff < op2);

  always_comb begin
    case (cond)
      3'b000:  cmp_hit = eq;
      3'b001:  cmp_hit = !eq;
      3'b010:  cmp_hit = slt;
      3'b011:  cmp_hit = slt || eq;
      3'b100:  cmp_hit = !slt && !eq;
      3'b101:  cmp_hit = !slt;
      3'b110:  cmp_hit = ult;
      default: cmp_hit = ult || eq;
    endcase
  end

  always_comb begin
    case (kind)
      K_CMP:   trig = cmp_hit;
      K_ADDZ:  trig = (sum == '0);
      K_ADDNZ: trig = (sum != '0);
      default: trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 skip_next <= 1'b0;
    else if (take && skip_next) skip_next <= 1'b0;
    else if (take)              skip_next <= trig;
  end

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !stall) |=> $stable(skip_next));

  // R8
  a_r8_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && skip_next) |=> !skip_next);

  // R10
  a_r10_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && !skip_next && kind == K_PLAIN) |=> !skip_next);

  // R6
  a_r6_addz: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && !skip_next && kind == K_ADDZ) |=> (skip_next == ($past(sum) == '0)));

  // R7
  a_r7_addnz: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && !skip_next && kind == K_ADDNZ) |=> (skip_next != ($past(sum) == '0)));

  // R2
  a_r2_imm_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    imm_sel |-> (op1_eff != '0 && $countones(op1_eff & (op1_eff - W'(1))) == 0
                 || op1_eff[W-1]));

  // R1
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> !skip_next);

endmodule

// File: tb/tb_skip_cond_unit.sv
module tb_skip_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, stall, imm_sel;
  logic [1:0]  kind;
  logic [2:0]  imm_code, cond;
  logic [15:0] op1_reg, op2, sum;
  logic [15:0] op1_eff;
  logic        skip_next;

  int n_checks = 0;
  int n_fail   = 0;
  logic exp_flag;

  always #2 clk = ~clk;

  skip_cond_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stall(stall), .kind(kind),
    .imm_sel(imm_sel), .imm_code(imm_code), .op1_reg(op1_reg), .op2(op2),
    .cond(cond), .sum(sum), .op1_eff(op1_eff), .skip_next(skip_next)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] imm_of(input logic [2:0] c);
    case (c)
      3'd0: return 16'd1;
      3'd1: return 16'd2;
      3'd2: return 16'd4;
      3'd3: return 16'd8;
      3'd4: return 16'hFFF8;
      3'd5: return 16'hFFFC;
      3'd6: return 16'hFFFE;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic cmp_of(input logic [2:0] c, input logic [15:0] a, input logic [15:0] b);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return sa < sb;
      3'd3: return sa <= sb;
      3'd4: return sa > sb;
      3'd5: return sa >= sb;
      3'd6: return int'(a) < int'(b);
      default: return int'(a) <= int'(b);
    endcase
  endfunction

  task automatic issue(input logic [1:0] k, input logic isel, input logic [2:0] ic,
                       input logic [15:0] a, input logic [15:0] b, input logic [2:0] c,
                       input logic [15:0] s, input string req);
    logic trig;
    @(negedge clk);
    in_valid = 1'b1; stall = 1'b0; kind = k; imm_sel = isel; imm_code = ic;
    op1_reg = a; op2 = b; cond = c; sum = s;
    case (k)
      2'b01:   trig = cmp_of(c, isel ? imm_of(ic) : a, b);
      2'b10:   trig = (s == 16'd0);
      2'b11:   trig = (s != 16'd0);
      default: trig = 1'b0;
    endcase
    exp_flag = exp_flag ? 1'b0 : trig;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(req, {15'd0, skip_next}, {15'd0, exp_flag});
  endtask

  task automatic plain(input string req);
    issue(2'b00, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'd0, req);
  endtask

  task automatic t_reset;
    check("R1", {15'd0, skip_next}, 16'd0);
  endtask

  task automatic t_imm;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      imm_sel = 1'b1; imm_code = 3'(c); op1_reg = 16'h1234;
      #1 check("R2", op1_eff, imm_of(3'(c)));
    end
    @(negedge clk);
    imm_sel = 1'b0; op1_reg = 16'hA5C3;
    #1 check("R2", op1_eff, 16'hA5C3);
  endtask

  task automatic t_compare;
    logic [15:0] pa[5] = '{16'h8000, 16'h0005, 16'hFFFF, 16'h0001, 16'h7FFF};
    logic [15:0] pb[5] = '{16'h7FFF, 16'h0005, 16'h0001, 16'hFFFF, 16'h8000};
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 5; p++) begin
        issue(2'b01, 1'b0, 3'd0, pa[p], pb[p], 3'(c), 16'd0,
              c < 2 ? "R3" : (c < 6 ? "R4" : "R5"));
        plain("R8");
      end
    end
    issue(2'b01, 1'b1, 3'd7, 16'd0, 16'hFFFF, 3'd0, 16'd0, "R3");
    plain("R8");
    issue(2'b01, 1'b1, 3'd4, 16'd0, 16'd0, 3'd2, 16'd0, "R4");
    plain("R8");
  endtask

  task automatic t_addskip;
    issue(2'b10, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'd0, "R6");
    plain("R8");
    issue(2'b10, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'h0100, "R6");
    issue(2'b11, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'h8000, "R7");
    plain("R8");
    issue(2'b11, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'd0, "R7");
  endtask

  task automatic t_chain;
    issue(2'b01, 1'b0, 3'd0, 16'd3, 16'd3, 3'd0, 16'd0, "R3");
    issue(2'b01, 1'b0, 3'd0, 16'd3, 16'd3, 3'd0, 16'd0, "R8");
    check("R8", {15'd0, skip_next}, 16'd0);
    issue(2'b10, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'd0, "R6");
    issue(2'b11, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'd7, "R8");
    check("R8", {15'd0, skip_next}, 16'd0);
  endtask

  task automatic t_hold;
    issue(2'b11, 1'b0, 3'd0, 16'd0, 16'd0, 3'd0, 16'd1, "R7");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; stall = 1'b1; kind = 2'b00;
      @(posedge clk); #1;
      check("R9", {15'd0, skip_next}, 16'd1);
    end
    @(negedge clk);
    in_valid = 1'b0; stall = 1'b0; kind = 2'b01; cond = 3'd1; op1_reg = 16'd1; op2 = 16'd2;
    @(posedge clk); #1;
    check("R9", {15'd0, skip_next}, 16'd1);
    @(negedge clk);
    in_valid = 1'b0; stall = 1'b1;
    @(posedge clk); #1;
    check("R9", {15'd0, skip_next}, 16'd1);
    stall = 1'b0;
    plain("R9");
  endtask

  task automatic t_plain;
    plain("R10");
    issue(2'b00, 1'b0, 3'd0, 16'd9, 16'd9, 3'd0, 16'd0, "R10");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; stall = 1'b0; kind = 2'b00; imm_sel = 1'b0;
    imm_code = 3'd0; op1_reg = 16'd0; op2 = 16'd0; cond = 3'd0; sum = 16'd0;
    exp_flag = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_imm();
    t_compare();
    t_addskip();
    t_chain();
    t_hold();
    t_plain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule